// File: doc/BRIEF.md
# Receive Packet Buffer with Overrun Drop and Descriptor Threshold Causes

This block sits between a receive byte stream and the logic that drains completed packets. Bytes arrive one per cycle, with a start flag on the first byte of a packet and an end flag on the last. They are written into a small circular store. The drain side only sees bytes from packets whose last byte has been stored. There is no backpressure on the input. When a byte arrives and the store has no room, the packet is abandoned as a whole. The write position moves back to where the packet began, and its remaining bytes are discarded until its end flag.

Beside the store, a descriptor ring tracker keeps a tail index, which software writes, and a head index, which advances each time hardware uses a descriptor. It reports how many descriptors are free. A low-water mark is chosen as 1/2, 1/4 or 1/8 of the ring size. When the free count first becomes equal to that mark, a cause bit is raised.

A second cause bit records overruns. Both cause bits stay set until software clears them with a one-cycle write-one-to-clear strobe. Every event also produces a one-cycle pulse that stops and re-arms the delayed receive interrupt timers. A hold level keeps those timers stopped until the next packet start is seen.

Top module: `rx_fifo_intr`

## Requirements
- R1: After reset, out_valid, irq_cause, timer_rearm and timer_halt are 0 and free_desc is 0.
- R2: The bytes of a packet that fits are read out in arrival order, with out_eop set on the last one. out_valid stays 0 until the cycle after the packet's end byte is written.
- R3: Bytes with in_valid set that arrive outside a packet are ignored. This means after an end byte or after a dropped packet has ended, and before the next start byte.
- R4: A write is an overrun if, when the byte arrives, the store already holds DEPTH bytes, counting unread committed bytes and the current packet's bytes. A read in the same cycle does not make room for that byte. On an overrun, none of that packet's bytes ever become readable, and irq_cause bit 1 is set on the next cycle.
- R5: A packet that starts after a dropped packet is stored and read normally.
- R6: After an overrun, the rest of that packet is discarded up to its end byte, and that packet raises no further overrun event.
- R7: free_desc equals (tail − head) modulo 2^RING_W. head_inc has no effect while free_desc is 0. A tail write loads the new tail on the next cycle.
- R8: The threshold is the ring size shifted right by 1, 2 or 3 for thr_sel values 0, 1 and 2. The value 3 behaves like 2.
- R9: irq_cause bit 0 is set on the cycle after free_desc becomes equal to the threshold. It is not set again while the two stay equal.
- R10: Each cause bit stays set until cause_clr has a 1 in its position. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R11: timer_rearm is 1 for exactly the cycle after each cycle that has an overrun or threshold event.
- R12: timer_halt becomes 1 together with timer_rearm. It returns to 0 after a cycle that accepts a byte with in_sop set and has no event.
- R13: A start byte that arrives in the middle of a packet discards the unfinished packet's bytes and begins a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on in_data |
| in_sop | input | 1 | This byte starts a packet |
| in_eop | input | 1 | This byte ends a packet |
| in_data | input | DATA_W | Received byte |
| out_rd | input | 1 | Consume the byte shown on out_data |
| out_valid | output | 1 | A committed byte is available |
| out_data | output | DATA_W | Oldest committed byte |
| out_eop | output | 1 | out_data is the last byte of its packet |
| tail_we | input | 1 | Load tail_val into the ring tail |
| tail_val | input | RING_W | New tail index |
| head_inc | input | 1 | Hardware used one descriptor |
| thr_sel | input | 2 | Threshold fraction select |
| cause_clr | input | 2 | Write-one-to-clear for the cause bits |
| irq_cause | output | 2 | bit 0 threshold reached, bit 1 overrun |
| timer_rearm | output | 1 | Pulse: stop and re-arm the delayed timers |
| timer_halt | output | 1 | Timers held until the next packet start |
| free_desc | output | RING_W | Free descriptor count |

## Verification
The bench fills the store to exactly DEPTH bytes and checks that nothing is dropped. Then it sends a start byte into the full store, and separately a packet longer than the store. A design with an off-by-one full test would either drop the packet that fits exactly or let a byte through into the full store. A design that rolled back the wrong way would leave part of the dropped packet readable. It also checks that a long dropped packet gives exactly one rearm pulse, that an unfinished packet cut short by a new start leaves nothing behind, and that the threshold cause fires once on entry into equality rather than on every cycle while equal. It checks the 1/4 and reserved-select thresholds as well. Finally, it checks that the set-over-clear priority, the modular free count across the index wrap, and the ignored head increment on an empty ring match a reference model that is compared against the design every cycle.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_RECV = 2'd1,
        RX_DROP = 2'd2
    } rx_state_e;

    localparam int CAUSE_THR = 0;
    localparam int CAUSE_OVR = 1;
    localparam int CAUSE_W   = 2;
endpackage

// File: rtl/rx_pkt_store.sv
module rx_pkt_store
    import rx_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_rd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eop,
    output logic              ovr_evt
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

    typedef struct packed {
        rx_state_e     st;
        logic [PW-1:0] wr;
        logic [PW-1:0] cm;
        logic [PW-1:0] rd;
    } store_t;

    store_t s_d, s_q;
    logic          wr_en;
    logic [PW-1:0] wr_addr;
    logic [DATA_W:0] mem [DEPTH];

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        wr_addr = s_q.wr;
        ovr_evt = 1'b0;
        if (in_valid) begin
            if (in_sop) begin
                // a new start always begins at the commit point
                if (PW'(s_q.cm - s_q.rd) == FULL_LVL) begin
                    ovr_evt = 1'b1;
                    s_d.wr  = s_q.cm;
                    s_d.st  = in_eop ? RX_IDLE : RX_DROP;
                end else begin
                    wr_en   = 1'b1;
                    wr_addr = s_q.cm;
                    s_d.wr  = s_q.cm + PW'(1);
                    if (in_eop) begin
                        s_d.cm = s_q.cm + PW'(1);
                        s_d.st = RX_IDLE;
                    end else begin
                        s_d.st = RX_RECV;
                    end
                end
            end else begin
                case (s_q.st)
                    RX_RECV: begin
                        if (PW'(s_q.wr - s_q.rd) == FULL_LVL) begin
                            ovr_evt = 1'b1;
                            s_d.wr  = s_q.cm;
                            s_d.st  = in_eop ? RX_IDLE : RX_DROP;
                        end else begin
                            wr_en   = 1'b1;
                            wr_addr = s_q.wr;
                            s_d.wr  = s_q.wr + PW'(1);
                            if (in_eop) begin
                                s_d.cm = s_q.wr + PW'(1);
                                s_d.st = RX_IDLE;
                            end
                        end
                    end
                    RX_DROP: begin
                        if (in_eop) s_d.st = RX_IDLE;
                    end
                    default: ;
                endcase
            end
        end
        if (out_rd && (s_q.rd != s_q.cm)) begin
            s_d.rd = s_q.rd + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: RX_IDLE, wr: '0, cm: '0, rd: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr[AW-1:0]] <= {in_eop, in_data};
        end
    end

    assign out_valid           = (s_q.rd != s_q.cm);
    assign {out_eop, out_data} = mem[s_q.rd[AW-1:0]];
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
    parameter int RING_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tail_we,
    input  logic [RING_W-1:0] tail_val,
    input  logic              head_inc,
    input  logic [1:0]        thr_sel,
    output logic [RING_W-1:0] free_desc,
    output logic              thr_evt
);
    localparam int RING_N = 1 << RING_W;
    localparam int TW     = RING_W + 1;

    typedef struct packed {
        logic [RING_W-1:0] tail;
        logic [RING_W-1:0] head;
        logic              eq_prev;
    } ring_t;

    ring_t r_d, r_q;
    logic [TW-1:0] thr_lvl;
    logic          eq_now;

    always_comb begin
        case (thr_sel)
            2'd0:    thr_lvl = TW'(RING_N >> 1);
            2'd1:    thr_lvl = TW'(RING_N >> 2);
            default: thr_lvl = TW'(RING_N >> 3);
        endcase
    end

    always_comb begin
        r_d       = r_q;
        free_desc = r_q.tail - r_q.head;
        eq_now    = ({1'b0, free_desc} == thr_lvl);
        thr_evt   = eq_now && !r_q.eq_prev;
        r_d.eq_prev = eq_now;
        if (head_inc && (free_desc != '0)) begin
            r_d.head = r_q.head + RING_W'(1);
        end
        if (tail_we) begin
            r_d.tail = tail_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/rx_intr_ctrl.sv
module rx_intr_ctrl
    import rx_fifo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ovr_evt,
    input  logic               thr_evt,
    input  logic               pkt_start,
    input  logic [CAUSE_W-1:0] cause_clr,
    output logic [CAUSE_W-1:0] irq_cause,
    output logic               timer_rearm,
    output logic               timer_halt
);
    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic               rearm;
        logic               halt;
    } intr_t;

    intr_t i_d, i_q;
    logic [CAUSE_W-1:0] evt;

    always_comb begin
        evt            = '0;
        evt[CAUSE_THR] = thr_evt;
        evt[CAUSE_OVR] = ovr_evt;
        i_d            = i_q;
        i_d.cause      = (i_q.cause & ~cause_clr) | evt;
        i_d.rearm      = |evt;
        if (|evt) begin
            i_d.halt = 1'b1;
        end else if (pkt_start) begin
            i_d.halt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign irq_cause   = i_q.cause;
    assign timer_rearm = i_q.rearm;
    assign timer_halt  = i_q.halt;
endmodule

// File: rtl/rx_fifo_intr.sv
module rx_fifo_intr
    import rx_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int RING_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_rd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eop,
    input  logic              tail_we,
    input  logic [RING_W-1:0] tail_val,
    input  logic              head_inc,
    input  logic [1:0]        thr_sel,
    input  logic [1:0]        cause_clr,
    output logic [1:0]        irq_cause,
    output logic              timer_rearm,
    output logic              timer_halt,
    output logic [RING_W-1:0] free_desc
);
    logic ovr_evt;
    logic thr_evt;

    rx_pkt_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .out_rd    (out_rd),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_eop   (out_eop),
        .ovr_evt   (ovr_evt)
    );

    rx_desc_ring #(.RING_W(RING_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .tail_we   (tail_we),
        .tail_val  (tail_val),
        .head_inc  (head_inc),
        .thr_sel   (thr_sel),
        .free_desc (free_desc),
        .thr_evt   (thr_evt)
    );

    rx_intr_ctrl u_intr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovr_evt     (ovr_evt),
        .thr_evt     (thr_evt),
        .pkt_start   (in_valid && in_sop),
        .cause_clr   (cause_clr),
        .irq_cause   (irq_cause),
        .timer_rearm (timer_rearm),
        .timer_halt  (timer_halt)
    );
endmodule

// File: rtl/rx_fifo_intr_chk.sv
module rx_fifo_intr_chk #(
    parameter int RING_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ovr_evt,
    input logic              thr_evt,
    input logic              tail_we,
    input logic [1:0]        cause_clr,
    input logic [1:0]        irq_cause,
    input logic              timer_rearm,
    input logic              timer_halt,
    input logic [RING_W-1:0] free_desc
);
    a_r4_ovr_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> irq_cause[1]);

    a_r9_thr_single: assert property (@(posedge clk) disable iff (!rst_n)
        thr_evt |=> !thr_evt);

    a_r11_rearm_follows_evt: assert property (@(posedge clk) disable iff (!rst_n)
        timer_rearm |-> $past(ovr_evt || thr_evt));

    a_r12_halt_with_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        timer_rearm |-> timer_halt);

    a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_cause[0]) && !$past(cause_clr[0])) |-> irq_cause[0]);

    a_r7_empty_ring_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(free_desc) == '0 && !$past(tail_we)) |-> (free_desc == '0));
endmodule

bind rx_fifo_intr rx_fifo_intr_chk #(.RING_W(RING_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovr_evt     (ovr_evt),
    .thr_evt     (thr_evt),
    .tail_we     (tail_we),
    .cause_clr   (cause_clr),
    .irq_cause   (irq_cause),
    .timer_rearm (timer_rearm),
    .timer_halt  (timer_halt),
    .free_desc   (free_desc)
);

// File: tb/rx_fifo_intr_bench.sv
`timescale 1ns/1ps
module rx_fifo_intr_bench;
    localparam int DW = 8;
    localparam int DP = 16;
    localparam int RW = 6;
    localparam int RN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_sop = 0, in_eop = 0;
    logic [DW-1:0] in_data = '0;
    logic out_rd = 0;
    logic out_valid, out_eop;
    logic [DW-1:0] out_data;
    logic tail_we = 0;
    logic [RW-1:0] tail_val = '0;
    logic head_inc = 0;
    logic [1:0] thr_sel = 2'd0;
    logic [1:0] cause_clr = 2'd0;
    logic [1:0] irq_cause;
    logic timer_rearm, timer_halt;
    logic [RW-1:0] free_desc;

    always #2 clk = ~clk;

    rx_fifo_intr #(.DATA_W(DW), .DEPTH(DP), .RING_W(RW)) u_rx_fifo_intr (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .out_rd(out_rd), .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop),
        .tail_we(tail_we), .tail_val(tail_val), .head_inc(head_inc),
        .thr_sel(thr_sel), .cause_clr(cause_clr), .irq_cause(irq_cause),
        .timer_rearm(timer_rearm), .timer_halt(timer_halt), .free_desc(free_desc)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    logic [DW:0] m_cm[$];
    logic [DW:0] m_pend[$];
    int m_st;          // 0 idle, 1 receiving, 2 dropping
    int m_tail, m_head;
    bit m_eqp, m_rearm, m_halt;
    bit [1:0] m_cause;

    always @(posedge clk) begin : model
        int fr, th;
        bit te, oe, rd_ok;
        if (!rst_n) begin
            m_cm.delete(); m_pend.delete();
            m_st = 0; m_tail = 0; m_head = 0;
            m_eqp = 0; m_rearm = 0; m_halt = 0; m_cause = 0;
        end else begin
            fr = (m_tail - m_head + RN) % RN;
            th = (thr_sel == 2'd0) ? RN/2 : (thr_sel == 2'd1) ? RN/4 : RN/8;
            te = (fr == th) && !m_eqp;
            m_eqp = (fr == th);
            oe = 0;
            rd_ok = out_rd && (m_cm.size() > 0);
            if (in_valid) begin
                if (in_sop) begin
                    m_pend.delete();
                    if (m_cm.size() == DP) begin
                        oe = 1; m_st = in_eop ? 0 : 2;
                    end else begin
                        m_pend.push_back({in_eop, in_data});
                        m_st = 1;
                    end
                end else if (m_st == 1) begin
                    if (m_cm.size() + m_pend.size() == DP) begin
                        oe = 1; m_pend.delete(); m_st = in_eop ? 0 : 2;
                    end else begin
                        m_pend.push_back({in_eop, in_data});
                    end
                end else if (m_st == 2 && in_eop) begin
                    m_st = 0;
                end
                if (m_st == 1 && in_eop) begin
                    foreach (m_pend[i]) m_cm.push_back(m_pend[i]);
                    m_pend.delete();
                    m_st = 0;
                end
            end
            if (rd_ok) void'(m_cm.pop_front());
            if (head_inc && fr != 0) m_head = (m_head + 1) % RN;
            if (tail_we) m_tail = int'(tail_val);
            m_cause[0] = te ? 1'b1 : (cause_clr[0] ? 1'b0 : m_cause[0]);
            m_cause[1] = oe ? 1'b1 : (cause_clr[1] ? 1'b0 : m_cause[1]);
            m_rearm = te || oe;
            if (te || oe) m_halt = 1;
            else if (in_valid && in_sop) m_halt = 0;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "out_valid", int'(out_valid), int'(m_cm.size() > 0));
            if (m_cm.size() > 0) begin
                chk("R2", "out_data", int'(out_data), int'(m_cm[0][DW-1:0]));
                chk("R2", "out_eop", int'(out_eop), int'(m_cm[0][DW]));
            end
            chk("R10", "irq_cause", int'(irq_cause), int'(m_cause));
            chk("R11", "timer_rearm", int'(timer_rearm), int'(m_rearm));
            chk("R12", "timer_halt", int'(timer_halt), int'(m_halt));
            chk("R7", "free_desc", int'(free_desc), (m_tail - m_head + RN) % RN);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit s, input bit e);
        in_valid = 1; in_sop = s; in_eop = e; in_data = d;
        tick();
        in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    task automatic read_byte(input string req, input logic [7:0] d, input bit e);
        chk(req, "read valid", int'(out_valid), 1);
        chk(req, "read data", int'(out_data), int'(d));
        chk(req, "read eop", int'(out_eop), int'(e));
        out_rd = 1;
        tick();
        out_rd = 0;
    endtask

    task automatic set_tail(input int v);
        tail_we = 1; tail_val = RW'(v);
        tick();
        tail_we = 0;
    endtask

    task automatic clr_cause(input logic [1:0] m);
        cause_clr = m;
        tick();
        cause_clr = 0;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int pulses;
        repeat (3) tick();
        rst_n = 1;
        // R1 reset state
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "irq_cause", int'(irq_cause), 0);
        chk("R1", "timer_rearm", int'(timer_rearm), 0);
        chk("R1", "timer_halt", int'(timer_halt), 0);
        chk("R1", "free_desc", int'(free_desc), 0);

        // R2 partial packet invisible, then full packet in order
        for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i), i == 0, 0);
        chk("R2", "partial hidden", int'(out_valid), 0);
        send_byte(8'h14, 0, 1);
        chk("R2", "visible after end", int'(out_valid), 1);
        for (int i = 0; i < 5; i++) read_byte("R2", 8'h10 + 8'(i), i == 4);
        chk("R2", "drained", int'(out_valid), 0);

        // R3 stray bytes outside a packet
        for (int i = 0; i < 3; i++) send_byte(8'hA0 + 8'(i), 0, i == 2);
        chk("R3", "stray ignored", int'(out_valid), 0);

        // R4 exact fill then start byte into full store
        for (int i = 0; i < DP; i++) send_byte(8'h20 + 8'(i), i == 0, i == DP-1);
        chk("R4", "exact fit no overrun", int'(irq_cause), 0);
        send_byte(8'h99, 1, 1);
        chk("R4", "overrun cause", int'(irq_cause[1]), 1);
        chk("R11", "rearm pulse", int'(timer_rearm), 1);
        chk("R12", "halt set", int'(timer_halt), 1);
        tick();
        chk("R11", "rearm one cycle", int'(timer_rearm), 0);
        for (int i = 0; i < DP; i++) read_byte("R4", 8'h20 + 8'(i), i == DP-1);
        chk("R4", "dropped byte absent", int'(out_valid), 0);
        clr_cause(2'b10);
        chk("R10", "overrun cleared", int'(irq_cause), 0);
        chk("R12", "halt held", int'(timer_halt), 1);

        // R4/R6 oversize packet: one event, no residue
        pulses = 0;
        for (int i = 0; i < DP + 4; i++) begin
            send_byte(8'h40 + 8'(i), i == 0, i == DP+3);
            if (timer_rearm) pulses++;
            if (i == 0) chk("R12", "halt released by start", int'(timer_halt), 0);
        end
        tick();
        chk("R6", "single rearm", pulses, 1);
        chk("R4", "no residue", int'(out_valid), 0);
        chk("R6", "after-drop stray ignored", int'(out_valid), 0);

        // R5 next packet normal
        for (int i = 0; i < 3; i++) send_byte(8'h60 + 8'(i), i == 0, i == 2);
        for (int i = 0; i < 3; i++) read_byte("R5", 8'h60 + 8'(i), i == 2);
        clr_cause(2'b10);

        // R13 restart mid-packet
        send_byte(8'h70, 1, 0);
        send_byte(8'h71, 0, 0);
        send_byte(8'h80, 1, 0);
        send_byte(8'h81, 0, 1);
        read_byte("R13", 8'h80, 0);
        read_byte("R13", 8'h81, 1);
        chk("R13", "abandoned bytes gone", int'(out_valid), 0);

        // R7/R9 ring and threshold at 1/2
        thr_sel = 2'd0;
        set_tail(40);
        chk("R7", "free after tail", int'(free_desc), 40);
        for (int i = 0; i < 8; i++) begin
            head_inc = 1; tick(); head_inc = 0;
        end
        chk("R9", "equal reached", int'(free_desc), 32);
        chk("R9", "cause not yet", int'(irq_cause[0]), 0);
        tick();
        chk("R9", "cause set", int'(irq_cause[0]), 1);
        chk("R11", "rearm on threshold", int'(timer_rearm), 1);
        clr_cause(2'b01);
        repeat (3) tick();
        chk("R9", "no refire while equal", int'(irq_cause[0]), 0);
        head_inc = 1; tick(); head_inc = 0;
        set_tail(41);
        tick();
        chk("R9", "refire on re-entry", int'(irq_cause[0]), 1);
        clr_cause(2'b01);

        // R10 set wins over clear
        head_inc = 1; tick(); head_inc = 0;
        set_tail(42);
        clr_cause(2'b01);
        chk("R10", "set beats clear", int'(irq_cause[0]), 1);
        clr_cause(2'b01);

        // R8 other fractions
        thr_sel = 2'd1;
        set_tail(26);
        tick();
        chk("R8", "quarter threshold", int'(irq_cause[0]), 1);
        clr_cause(2'b01);
        thr_sel = 2'd3;
        set_tail(18);
        tick();
        chk("R8", "reserved acts as eighth", int'(irq_cause[0]), 1);
        clr_cause(2'b01);

        // R7 empty ring ignores head_inc, wrap of the count
        set_tail(10);
        head_inc = 1; tick(); head_inc = 0;
        chk("R7", "head_inc ignored", int'(free_desc), 0);
        set_tail(5);
        chk("R7", "wrapped count", int'(free_desc), 59);

        repeat (3) tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule